// File: doc/BRIEF.md
# Stack and Interrupt Entry Sequencer

This block carries out the stack-based control-flow operations of an 8-bit processor. It owns the 8-bit stack pointer and drives a byte-wide port to a synchronous memory. A stack location is formed by ORing a page base parameter with the pointer. A write stores at the current pointer and then decrements it. A read increments the pointer first and then fetches. The memory returns read data one cycle after the read strobe.

The host issues a command on a single-cycle strobe while the block is idle. The commands are: push a byte, pull a byte, call a subroutine, return from a subroutine, return from an interrupt, software break, maskable interrupt entry, non-maskable interrupt entry, and reset entry. The block steps through the memory accesses for that command. It then presents the new program counter, the new status byte or the pulled byte as registered results, with load strobes and a one-cycle completion pulse. Deciding which interrupt to take, and when, belongs to the surrounding core.

Top module: `stack_seq`

## Requirements
- R1: After reset the stack pointer reads 0xFF, and `done`, `busy`, `pc_load` and `status_load` are all low.
- R2: A push (code 0) writes `cmd_data` at address BASE|SP and then lowers SP by one. Every stack write lies in the BASE page.
- R3: A pull (code 1) raises SP by one and then reads BASE|SP. The byte read appears on `pull_data` when `done` is high.
- R4: A call (code 2) pushes `pc_in`+2, high byte first and low byte second. It then loads `target_in` as the new program counter.
- R5: A subroutine return (code 3) pulls the low byte and then the high byte. It loads the rebuilt value plus one.
- R6: An interrupt return (code 4) pulls the status byte first and then the program counter, low byte then high byte. It loads both values unchanged.
- R7: Break (code 5), maskable entry (code 6) and non-maskable entry (code 7) each push three bytes in this order: PC high, PC low, then `status_in` unchanged. SP drops by three.
- R8: Entries load the program counter from a little-endian vector, low byte at the vector address and high byte at the next address. The vector is at 0xFFFA for non-maskable entry, 0xFFFC for reset, and 0xFFFE for both break and maskable entry.
- R9: The B flag is status bit 4. After break the status output is `status_in` with bit 4 set. After maskable or non-maskable entry it is `status_in` with bit 4 cleared.
- R10: Reset entry (code 8) sets SP to 0xFF, loads status 0x00 and loads the reset vector. It performs no memory write.
- R11: SP wraps modulo 256. A pull from 0xFF reads BASE|0x00, and a push at 0x00 leaves 0xFF.
- R12: `done` is high for exactly one cycle per command, and never while `busy` is high. A strobe while busy has no effect, and neither do codes 9 to 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe, taken only while idle |
| cmd_op | input | 4 | Command code (0 push .. 8 reset entry) |
| cmd_data | input | 8 | Byte to push |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| target_in | input | 16 | Call destination |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| pc_out | output | 16 | New program counter |
| pc_load | output | 1 | `pc_out` is valid with `done` |
| status_out | output | 8 | New status byte |
| status_load | output | 1 | `status_out` is valid with `done` |
| pull_data | output | 8 | Byte taken by a pull |
| sp_out | output | 8 | Current stack pointer |
| mem_addr | output | 16 | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_re | output | 1 | Memory read strobe |
| mem_rdata | input | 8 | Read data, one cycle after `mem_re` |

## Verification
The bench targets the byte orders of the program counter. Swapped orders would leave the low byte at the higher address, so the return test would land at a wrong address. It checks the pointer convention at both ends of the 8-bit range, where a read-then-increment design would fetch the byte one slot away. The wrap test would catch a pointer that saturates instead of wrapping. It checks each entry's vector and B flag, where a shared vector or a B flag written into the pushed byte shows up as a wrong program counter or a wrong stored status. It also checks the extra one added on return but not on interrupt return. Finally it drives strobes while busy and undefined codes, which would cause stray writes or an extra `done` if taken.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

  localparam int STEP_W = 3;

  typedef enum logic [3:0] {
    OP_PUSH  = 4'd0,
    OP_PULL  = 4'd1,
    OP_CALL  = 4'd2,
    OP_RET   = 4'd3,
    OP_RTI   = 4'd4,
    OP_BRK   = 4'd5,
    OP_IRQ   = 4'd6,
    OP_NMI   = 4'd7,
    OP_RESET = 4'd8
  } op_e;

  typedef enum logic [3:0] {
    U_END,
    U_WR_DATA,
    U_WR_PCH,
    U_WR_PCL,
    U_WR_ST,
    U_RD_DATA,
    U_RD_PCL,
    U_RD_PCH,
    U_RD_ST,
    U_RD_VL,
    U_RD_VH
  } uop_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_RUN,
    S_FIN
  } state_e;

endpackage

// File: rtl/stack_seq_plan.sv
module stack_seq_plan
  import stack_seq_pkg::*;
(
  input  logic [3:0]        op,
  input  logic [STEP_W-1:0] step,
  output uop_e              uop
);

  // Per-command micro-op order; every list is closed by U_END.
  always_comb begin
    uop = U_END;
    case (op)
      OP_PUSH: if (step == 0) uop = U_WR_DATA;
      OP_PULL: if (step == 0) uop = U_RD_DATA;
      OP_CALL:
        case (step)
          3'd0:    uop = U_WR_PCH;
          3'd1:    uop = U_WR_PCL;
          default: uop = U_END;
        endcase
      OP_RET:
        case (step)
          3'd0:    uop = U_RD_PCL;
          3'd1:    uop = U_RD_PCH;
          default: uop = U_END;
        endcase
      OP_RTI:
        case (step)
          3'd0:    uop = U_RD_ST;
          3'd1:    uop = U_RD_PCL;
          3'd2:    uop = U_RD_PCH;
          default: uop = U_END;
        endcase
      OP_BRK, OP_IRQ, OP_NMI:
        case (step)
          3'd0:    uop = U_WR_PCH;
          3'd1:    uop = U_WR_PCL;
          3'd2:    uop = U_WR_ST;
          3'd3:    uop = U_RD_VL;
          3'd4:    uop = U_RD_VH;
          default: uop = U_END;
        endcase
      OP_RESET:
        case (step)
          3'd0:    uop = U_RD_VL;
          3'd1:    uop = U_RD_VH;
          default: uop = U_END;
        endcase
      default: uop = U_END;
    endcase
  end

endmodule

// File: rtl/stack_seq_mem.sv
module stack_seq_mem
  import stack_seq_pkg::*;
#(
  parameter logic [15:0] BASE = 16'h0100
) (
  input  uop_e        uop,
  input  logic        active,
  input  logic [7:0]  sp,
  input  logic [15:0] vec,
  input  logic [15:0] pc_work,
  input  logic [7:0]  st_work,
  input  logic [7:0]  data_work,
  output logic [15:0] addr,
  output logic        we,
  output logic        re,
  output logic [7:0]  wdata,
  output logic [7:0]  sp_next
);

  logic [7:0] sp_inc;
  logic [7:0] sp_dec;

  assign sp_inc = sp + 8'd1;
  assign sp_dec = sp - 8'd1;

  always_comb begin
    addr    = BASE | {8'h00, sp};
    we      = 1'b0;
    re      = 1'b0;
    wdata   = 8'h00;
    sp_next = sp;
    if (active) begin
      case (uop)
        U_WR_DATA, U_WR_PCH, U_WR_PCL, U_WR_ST: begin
          we      = 1'b1;
          sp_next = sp_dec;
          case (uop)
            U_WR_PCH: wdata = pc_work[15:8];
            U_WR_PCL: wdata = pc_work[7:0];
            U_WR_ST:  wdata = st_work;
            default:  wdata = data_work;
          endcase
        end
        U_RD_DATA, U_RD_PCL, U_RD_PCH, U_RD_ST: begin
          re      = 1'b1;
          sp_next = sp_inc;
          addr    = BASE | {8'h00, sp_inc};
        end
        U_RD_VL: begin
          re   = 1'b1;
          addr = vec;
        end
        U_RD_VH: begin
          re   = 1'b1;
          addr = vec + 16'd1;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
  import stack_seq_pkg::*;
#(
  parameter logic [15:0] BASE      = 16'h0100,
  parameter logic [15:0] VEC_NMI   = 16'hFFFA,
  parameter logic [15:0] VEC_RESET = 16'hFFFC,
  parameter logic [15:0] VEC_IRQ   = 16'hFFFE,
  parameter int          B_BIT     = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  input  logic [3:0]  cmd_op,
  input  logic [7:0]  cmd_data,
  input  logic [15:0] pc_in,
  input  logic [7:0]  status_in,
  input  logic [15:0] target_in,
  output logic        busy,
  output logic        done,
  output logic [15:0] pc_out,
  output logic        pc_load,
  output logic [7:0]  status_out,
  output logic        status_load,
  output logic [7:0]  pull_data,
  output logic [7:0]  sp_out,
  output logic [15:0] mem_addr,
  output logic        mem_we,
  output logic [7:0]  mem_wdata,
  output logic        mem_re,
  input  logic [7:0]  mem_rdata
);

  localparam logic [7:0] B_MASK = 8'(1) << B_BIT;

  state_e            state_q;
  logic [3:0]        op_q;
  logic [STEP_W-1:0] step_q;
  logic [7:0]        sp_q;
  logic [15:0]       pc_work, target_q, vec_q;
  logic [7:0]        st_work, data_work;
  logic [7:0]        lo_q, hi_q, st_pull;
  logic              rd_pend;
  uop_e              rd_dst;
  uop_e              uop;
  logic [7:0]        sp_next;
  logic              accept;

  assign accept = (state_q == S_IDLE) && cmd_valid && (cmd_op <= OP_RESET);
  assign busy   = (state_q != S_IDLE);
  assign sp_out = sp_q;

  stack_seq_plan u_plan (
    .op   (op_q),
    .step (step_q),
    .uop  (uop)
  );

  stack_seq_mem #(.BASE(BASE)) u_mem (
    .uop       (uop),
    .active    (state_q == S_RUN),
    .sp        (sp_q),
    .vec       (vec_q),
    .pc_work   (pc_work),
    .st_work   (st_work),
    .data_work (data_work),
    .addr      (mem_addr),
    .we        (mem_we),
    .re        (mem_re),
    .wdata     (mem_wdata),
    .sp_next   (sp_next)
  );

  // Read data returns one cycle after the strobe; steer it by the op that asked.
  always_ff @(posedge clk) begin
    if (rst) begin
      lo_q    <= 8'h00;
      hi_q    <= 8'h00;
      st_pull <= 8'h00;
    end else if (rd_pend) begin
      case (rd_dst)
        U_RD_PCL, U_RD_VL: lo_q    <= mem_rdata;
        U_RD_PCH, U_RD_VH: hi_q    <= mem_rdata;
        U_RD_ST:           st_pull <= mem_rdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= S_IDLE;
      op_q        <= 4'd0;
      step_q      <= '0;
      sp_q        <= 8'hFF;
      pc_work     <= 16'h0000;
      target_q    <= 16'h0000;
      vec_q       <= VEC_IRQ;
      st_work     <= 8'h00;
      data_work   <= 8'h00;
      rd_pend     <= 1'b0;
      rd_dst      <= U_END;
      done        <= 1'b0;
      pc_load     <= 1'b0;
      status_load <= 1'b0;
      pc_out      <= 16'h0000;
      status_out  <= 8'h00;
      pull_data   <= 8'h00;
    end else begin
      done        <= 1'b0;
      pc_load     <= 1'b0;
      status_load <= 1'b0;
      if (rd_pend && rd_dst == U_RD_DATA) data_work <= mem_rdata;
      case (state_q)
        S_IDLE: if (accept) begin
          state_q   <= S_RUN;
          op_q      <= cmd_op;
          step_q    <= '0;
          pc_work   <= (cmd_op == OP_CALL) ? pc_in + 16'd2 : pc_in;
          target_q  <= target_in;
          st_work   <= status_in;
          data_work <= cmd_data;
          case (cmd_op)
            OP_NMI:   vec_q <= VEC_NMI;
            OP_RESET: vec_q <= VEC_RESET;
            default:  vec_q <= VEC_IRQ;
          endcase
          if (cmd_op == OP_RESET) sp_q <= 8'hFF;
        end
        S_RUN: begin
          sp_q    <= sp_next;
          rd_pend <= mem_re;
          rd_dst  <= uop;
          if (uop == U_END) state_q <= S_FIN;
          else              step_q  <= step_q + 1'b1;
        end
        default: begin
          state_q <= S_IDLE;
          rd_pend <= 1'b0;
          done    <= 1'b1;
          case (op_q)
            OP_PULL: pull_data <= data_work;
            OP_CALL: begin
              pc_out  <= target_q;
              pc_load <= 1'b1;
            end
            OP_RET: begin
              pc_out  <= {hi_q, lo_q} + 16'd1;
              pc_load <= 1'b1;
            end
            OP_RTI: begin
              pc_out      <= {hi_q, lo_q};
              pc_load     <= 1'b1;
              status_out  <= st_pull;
              status_load <= 1'b1;
            end
            OP_BRK, OP_IRQ, OP_NMI: begin
              pc_out      <= {hi_q, lo_q};
              pc_load     <= 1'b1;
              status_out  <= (op_q == OP_BRK) ? (st_work | B_MASK) : (st_work & ~B_MASK);
              status_load <= 1'b1;
            end
            OP_RESET: begin
              pc_out      <= {hi_q, lo_q};
              pc_load     <= 1'b1;
              status_out  <= 8'h00;
              status_load <= 1'b1;
            end
            default: ;
          endcase
        end
      endcase
    end
  end

endmodule

// File: rtl/stack_seq_chk.sv
module stack_seq_chk #(
  parameter logic [15:0] BASE = 16'h0100
) (
  input logic        clk,
  input logic        rst,
  input logic        busy,
  input logic        done,
  input logic        mem_we,
  input logic        mem_re,
  input logic [15:0] mem_addr,
  input logic [7:0]  sp_out
);

  assert_write_in_page_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[15:8] == BASE[15:8]) && (mem_addr[7:0] == sp_out));

  assert_write_then_dec_R2: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> (sp_out == $past(sp_out) - 8'd1));

  assert_inc_then_read_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_re && mem_addr[15:8] == BASE[15:8]) |-> (mem_addr[7:0] == sp_out + 8'd1));

  assert_done_single_R12: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R12: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_port_exclusive_R2: assert property (@(posedge clk) disable iff (rst)
    !(mem_we && mem_re));

  assert_quiet_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !(mem_we || mem_re));

endmodule

bind stack_seq stack_seq_chk #(.BASE(BASE)) u_stack_seq_chk (
  .clk      (clk),
  .rst      (rst),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .sp_out   (sp_out)
);

// File: tb/test_stack_seq.sv
`timescale 1ns/1ps
module test_stack_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_op = 4'd0;
  logic [7:0]  cmd_data = 8'h00;
  logic [15:0] pc_in = 16'h0000;
  logic [7:0]  status_in = 8'h00;
  logic [15:0] target_in = 16'h0000;
  logic        busy, done, pc_load, status_load;
  logic [15:0] pc_out, mem_addr;
  logic [7:0]  status_out, pull_data, sp_out, mem_wdata;
  logic        mem_we, mem_re;
  logic [7:0]  mem_rdata = 8'h00;

  int n_checks = 0;
  int n_fail   = 0;
  int done_cnt = 0;

  // Model RAM: stack page and top page, indexed by {addr[15], addr[7:0]}.
  logic [7:0]  ram [512];
  logic [15:0] wlog_a [64];
  logic [7:0]  wlog_d [64];
  int          wtotal = 0;

  always #4 clk = ~clk;

  stack_seq i_stack_seq (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_data(cmd_data), .pc_in(pc_in), .status_in(status_in),
    .target_in(target_in), .busy(busy), .done(done), .pc_out(pc_out),
    .pc_load(pc_load), .status_out(status_out), .status_load(status_load),
    .pull_data(pull_data), .sp_out(sp_out), .mem_addr(mem_addr),
    .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_re(mem_re),
    .mem_rdata(mem_rdata)
  );

  function automatic int idx(logic [15:0] a);
    return int'({a[15], a[7:0]});
  endfunction

  always @(posedge clk) begin
    if (mem_we) begin
      ram[idx(mem_addr)]      <= mem_wdata;
      wlog_a[wtotal % 64]     <= mem_addr;
      wlog_d[wtotal % 64]     <= mem_wdata;
      wtotal                  <= wtotal + 1;
    end
    if (mem_re) mem_rdata <= ram[idx(mem_addr)];
    if (done) done_cnt <= done_cnt + 1;
  end

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Issue one command and wait until done; returns the index of the first write.
  task automatic issue(logic [3:0] op, logic [7:0] d, logic [15:0] pc,
                       logic [7:0] st, logic [15:0] tgt, output int w0);
    @(negedge clk);
    w0 = wtotal;
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    pc_in = pc; status_in = st; target_in = tgt;
    @(negedge clk);
    cmd_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  task automatic check_write(string req, int k, logic [15:0] a, logic [7:0] d);
    check(req, wlog_a[k % 64], a);
    check(req, {8'h00, wlog_d[k % 64]}, {8'h00, d});
  endtask

  task automatic t_reset_state;
    check("R1 sp", {8'h00, sp_out}, 16'h00FF);
    check("R1 flags", {12'h000, done, busy, pc_load, status_load}, 16'h0000);
  endtask

  task automatic t_push_pull;
    int w0;
    int c0;
    issue(4'd0, 8'hA5, 16'h0, 8'h0, 16'h0, w0);
    check("R2 done", {15'h0, done}, 16'h0001);
    check_write("R2 push1", w0, 16'h01FF, 8'hA5);
    check("R2 sp", {8'h00, sp_out}, 16'h00FE);
    issue(4'd0, 8'h3C, 16'h0, 8'h0, 16'h0, w0);
    check_write("R2 push2", w0, 16'h01FE, 8'h3C);
    issue(4'd1, 8'h00, 16'h0, 8'h0, 16'h0, w0);
    check("R3 pull data", {8'h00, pull_data}, 16'h003C);
    check("R3 sp", {8'h00, sp_out}, 16'h00FE);
    c0 = done_cnt;
    @(negedge clk);
    check("R12 done width", {15'h0, done}, 16'h0000);
    check("R12 done count", 16'(done_cnt - c0), 16'd1);
    issue(4'd1, 8'h00, 16'h0, 8'h0, 16'h0, w0);
    check("R3 pull data 2", {8'h00, pull_data}, 16'h00A5);
    check("R3 no writes", 16'(wtotal - w0), 16'd0);
  endtask

  task automatic t_wrap;
    int w0;
    ram[idx(16'h0100)] = 8'h5A;
    issue(4'd1, 8'h00, 16'h0, 8'h0, 16'h0, w0);
    check("R11 pull wrap data", {8'h00, pull_data}, 16'h005A);
    check("R11 pull wrap sp", {8'h00, sp_out}, 16'h0000);
    issue(4'd0, 8'h99, 16'h0, 8'h0, 16'h0, w0);
    check_write("R11 push at 00", w0, 16'h0100, 8'h99);
    check("R11 push wrap sp", {8'h00, sp_out}, 16'h00FF);
  endtask

  task automatic t_call_return;
    int w0;
    issue(4'd2, 8'h00, 16'h1234, 8'h0, 16'hABCD, w0);
    check_write("R4 high first", w0, 16'h01FF, 8'h12);
    check_write("R4 low second", w0 + 1, 16'h01FE, 8'h36);
    check("R4 pc", pc_out, 16'hABCD);
    check("R4 load", {15'h0, pc_load}, 16'h0001);
    check("R4 sp", {8'h00, sp_out}, 16'h00FD);
    issue(4'd3, 8'h00, 16'h0, 8'h0, 16'h0, w0);
    check("R5 pc plus one", pc_out, 16'h1237);
    check("R5 sp", {8'h00, sp_out}, 16'h00FF);
  endtask

  task automatic t_break_rti;
    int w0;
    issue(4'd5, 8'h00, 16'h4567, 8'h0F, 16'h0, w0);
    check_write("R7 pch", w0, 16'h01FF, 8'h45);
    check_write("R7 pcl", w0 + 1, 16'h01FE, 8'h67);
    check_write("R7 status unchanged", w0 + 2, 16'h01FD, 8'h0F);
    check("R7 sp", {8'h00, sp_out}, 16'h00FC);
    check("R8 break vector", pc_out, 16'h8000);
    check("R9 break sets B", {8'h00, status_out}, 16'h001F);
    issue(4'd4, 8'h00, 16'h0, 8'h0, 16'h0, w0);
    check("R6 pc no increment", pc_out, 16'h4567);
    check("R6 status", {8'h00, status_out}, 16'h000F);
    check("R6 status load", {15'h0, status_load}, 16'h0001);
    check("R6 sp", {8'h00, sp_out}, 16'h00FF);
  endtask

  task automatic t_irq_nmi;
    int w0;
    issue(4'd6, 8'h00, 16'h2000, 8'hFF, 16'h0, w0);
    check_write("R7 irq status push", w0 + 2, 16'h01FD, 8'hFF);
    check("R8 irq vector", pc_out, 16'h8000);
    check("R9 irq clears B", {8'h00, status_out}, 16'h00EF);
    issue(4'd4, 8'h00, 16'h0, 8'h0, 16'h0, w0);
    check("R6 irq return pc", pc_out, 16'h2000);
    issue(4'd7, 8'h00, 16'h3001, 8'h10, 16'h0, w0);
    check_write("R7 nmi pch", w0, 16'h01FF, 8'h30);
    check_write("R7 nmi status push", w0 + 2, 16'h01FD, 8'h10);
    check("R8 nmi vector", pc_out, 16'h9234);
    check("R9 nmi clears B", {8'h00, status_out}, 16'h0000);
  endtask

  task automatic t_reset_entry;
    int w0;
    check("R10 sp before", {8'h00, sp_out}, 16'h00FC);
    issue(4'd8, 8'h00, 16'h0, 8'hFF, 16'h0, w0);
    check("R10 sp", {8'h00, sp_out}, 16'h00FF);
    check("R10 status", {8'h00, status_out}, 16'h0000);
    check("R10 status load", {15'h0, status_load}, 16'h0001);
    check("R8 reset vector", pc_out, 16'hC010);
    check("R10 no writes", 16'(wtotal - w0), 16'd0);
  endtask

  task automatic t_ignored;
    int w0;
    int c0;
    @(negedge clk);
    w0 = wtotal; c0 = done_cnt;
    cmd_valid = 1'b1; cmd_op = 4'd0; cmd_data = 8'h11;
    @(negedge clk);
    cmd_data = 8'h22;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R12 one write while busy", 16'(wtotal - w0), 16'd1);
    check_write("R12 first command kept", w0, 16'h01FF, 8'h11);
    check("R12 sp", {8'h00, sp_out}, 16'h00FE);
    check("R12 one done", 16'(done_cnt - c0), 16'd1);
    w0 = wtotal; c0 = done_cnt;
    cmd_valid = 1'b1; cmd_op = 4'd15; cmd_data = 8'h77;
    @(negedge clk);
    cmd_valid = 1'b0;
    repeat (10) @(negedge clk);
    check("R12 undefined code writes", 16'(wtotal - w0), 16'd0);
    check("R12 undefined code done", 16'(done_cnt - c0), 16'd0);
    check("R12 undefined code sp", {8'h00, sp_out}, 16'h00FE);
  endtask

  initial begin
    for (int i = 0; i < 512; i++) ram[i] = 8'h00;
    ram[idx(16'hFFFE)] = 8'h00; ram[idx(16'hFFFF)] = 8'h80;
    ram[idx(16'hFFFA)] = 8'h34; ram[idx(16'hFFFB)] = 8'h92;
    ram[idx(16'hFFFC)] = 8'h10; ram[idx(16'hFFFD)] = 8'hC0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset_state();
    t_push_pull();
    t_wrap();
    t_call_return();
    t_break_rti();
    t_irq_nmi();
    t_reset_entry();
    t_ignored();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule